// File: doc/BRIEF.md
# DMA Interrupt Status and Register Decoder

This block is the register front end of a multi-channel DMA engine. It decodes a 4 KB byte-addressed window of 32-bit words. The window holds the global registers, one five-word register bank for each channel, and a read-only identification area at the top. The transfer datapath sits outside this block. It reports the end of each transfer and each bus error as one-cycle set pulses per channel. It reads back the channel register contents and the per-channel run enables that this block drives.

Each channel's configuration word selects whether that channel's terminal-count and error events reach the interrupt line. There are no separate mask registers. The raw event bits stay set until software writes a one to the matching bit of a clear register. The single interrupt output is the OR of all unmasked raw bits. Any access to an offset that is not defined reads as zero and sets a sticky decode-error flag, which only reset clears.

Top module: `dma_regfront`

## Requirements
- R1: After a synchronous active-low reset, every stored register and raw event bit is zero, and `irq`, `dec_err`, `rdata` and `chan_enable` are all low.
- R2: Channel c has five read/write words at byte offsets 0x100 + 32·c + {0x0, 0x4, 0x8, 0xC, 0x10}, in the order source, destination, link, control, configuration. The word at +0x10 is the configuration.
- R3: The global configuration word at 0x30 and the sync word at 0x34 are read/write and hold all 32 bits.
- R4: A one on `tc_set[c]` or `err_set[c]` sets raw bit c in the following cycle. The raw terminal-count bits read at 0x14 and the raw error bits read at 0x18, with bit c belonging to channel c.
- R5: A write to 0x08 clears every raw terminal-count bit that is one in `wdata`. A write to 0x10 does the same for the raw error bits.
- R6: When a set pulse and a clear write hit the same bit in the same cycle, the bit ends up set.
- R7: The terminal-count mask of channel c is bit 15 of its configuration word, and the error mask is bit 14. Offset 0x04 reads raw TC AND mask. Offset 0x0C reads raw error AND mask. Offset 0x00 reads the OR of those two.
- R8: `irq` is high exactly when the value at 0x00 is nonzero. It follows the stored state with no added register.
- R9: Bit c of the word at 0x1C, and `chan_enable[c]`, equal bit 0 of channel c's configuration word.
- R10: Words 0xFE0 to 0xFFC return one identification byte each in bits 7:0, in the order 0x80 (0x81 unless NUM_CH is 8), 0x10, 0x04, 0x0A, 0x0D, 0xF0, 0x05, 0xB1.
- R11: Offsets 0x20 to 0x2C read as zero, ignore writes, and do not set `dec_err`.
- R12: The following are invalid: a bank access with a channel index of NUM_CH or more, or with a word index above 4; a read of 0x08, 0x10, 0x38 or 0x3C; a write to any other global word, or to the identification area; and any other offset. An invalid access reads zero, has no effect, and sets `dec_err` from the next cycle until reset.
- R13: `rdata` is registered. It shows the addressed word in the cycle after `rd_en` and holds its value in every cycle without `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Read strobe for one cycle |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | 12 | Byte address within the window (bits 1:0 ignored) |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| tc_set | input | NUM_CH | Per-channel terminal-count event pulses |
| err_set | input | NUM_CH | Per-channel error event pulses |
| chan_enable | output | NUM_CH | Per-channel run enable taken from configuration bit 0 |
| irq | output | 1 | Combined interrupt, active high |
| dec_err | output | 1 | Sticky flag for an invalid access |

## Verification
The assertions assume that `rd_en` and `wr_en` never go high in the same cycle. The clear-register property also assumes that no set pulse lands in the cycle of the clear write; the set-wins case is covered by a separate bench check. The bench drives every access from single-strobe tasks, so reads and writes never overlap. It raises set pulses in idle cycles, except in the one deliberate set-and-clear collision. The bench uses four channels, so both valid and out-of-range channel indexes can be reached. It sweeps all sixteen terminal-count mask patterns against fixed raw patterns.

// File: rtl/dma_rf_pkg.sv
// Shared offsets and identification lookup for the DMA register front end.
// Assumes 32-bit words and a 4 KB window; word selectors are addr[5:2].
package dma_rf_pkg;
    localparam int WIN_AW = 12;
    // Global word selectors (addr[5:2])
    localparam logic [3:0] G_STAT_ALL = 4'd0;
    localparam logic [3:0] G_STAT_TC  = 4'd1;
    localparam logic [3:0] G_CLR_TC   = 4'd2;
    localparam logic [3:0] G_STAT_ERR = 4'd3;
    localparam logic [3:0] G_CLR_ERR  = 4'd4;
    localparam logic [3:0] G_RAW_TC   = 4'd5;
    localparam logic [3:0] G_RAW_ERR  = 4'd6;
    localparam logic [3:0] G_ENABLES  = 4'd7;
    localparam logic [3:0] G_GCFG     = 4'd12;
    localparam logic [3:0] G_SYNC     = 4'd13;
    localparam int BANK_WORDS = 5;
    localparam int CFG_WORD   = 4;
    localparam int TCMASK_BIT = 15;
    localparam int ERMASK_BIT = 14;
    localparam int RUN_BIT    = 0;

    // Identification byte for word idx of the ID area.
    function automatic logic [7:0] id_byte(input logic [2:0] idx, input logic full);
        case (idx)
            3'd0:    id_byte = full ? 8'h80 : 8'h81;
            3'd1:    id_byte = 8'h10;
            3'd2:    id_byte = 8'h04;
            3'd3:    id_byte = 8'h0A;
            3'd4:    id_byte = 8'h0D;
            3'd5:    id_byte = 8'hF0;
            3'd6:    id_byte = 8'h05;
            default: id_byte = 8'hB1;
        endcase
    endfunction
endpackage

// File: rtl/dma_rf_chbank.sv
// One channel's five-word register bank (source, destination, link,
// control, configuration). Assumes wsel/rsel are below 5 whenever
// the caller relies on the result; other selectors write nothing, read zero.
module dma_rf_chbank #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [2:0]        wsel,
    input  logic [DATA_W-1:0] wdata,
    input  logic [2:0]        rsel,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] cfg
);
    import dma_rf_pkg::*;

    logic [DATA_W-1:0] words [BANK_WORDS];

    // Store a written word into the selected slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < BANK_WORDS; r++) words[r] <= '0;
        end else if (we) begin
            for (int r = 0; r < BANK_WORDS; r++)
                if (wsel == 3'(r)) words[r] <= wdata;
        end
    end

    // Select the word being read.
    always_comb begin
        rdata = '0;
        for (int r = 0; r < BANK_WORDS; r++)
            if (rsel == 3'(r)) rdata = words[r];
    end

    assign cfg = words[CFG_WORD];
endmodule

// File: rtl/dma_rf_irq.sv
// Raw terminal-count and error event bits with write-one-to-clear,
// masking and the combined interrupt. Assumes set pulses are one cycle.
// A set and a clear of the same bit in one cycle leave the bit set.
module dma_rf_irq #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] tc_set,
    input  logic [NUM_CH-1:0] err_set,
    input  logic              tc_clr_we,
    input  logic              err_clr_we,
    input  logic [NUM_CH-1:0] clr_val,
    input  logic [NUM_CH-1:0] tc_mask,
    input  logic [NUM_CH-1:0] err_mask,
    output logic [NUM_CH-1:0] raw_tc,
    output logic [NUM_CH-1:0] raw_err,
    output logic [NUM_CH-1:0] tc_stat,
    output logic [NUM_CH-1:0] err_stat,
    output logic              irq
);
    logic [NUM_CH-1:0] tc_keep, err_keep;

    // Bits that survive this cycle's clear writes.
    assign tc_keep  = tc_clr_we  ? ~clr_val : '1;
    assign err_keep = err_clr_we ? ~clr_val : '1;

    // Update raw bits: clear first, then new events win.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_tc  <= '0;
            raw_err <= '0;
        end else begin
            raw_tc  <= (raw_tc  & tc_keep)  | tc_set;
            raw_err <= (raw_err & err_keep) | err_set;
        end
    end

    // Masked views and the combined interrupt.
    assign tc_stat  = raw_tc  & tc_mask;
    assign err_stat = raw_err & err_mask;
    assign irq      = |(tc_stat | err_stat);
endmodule

// File: rtl/dma_regfront.sv
// Register decoder for a multi-channel DMA engine: global status/clear,
// configuration and sync words, per-channel banks and identification bytes.
// Assumes rd_en and wr_en are not high together and NUM_CH is 1..8.
module dma_regfront #(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [11:0]       addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [NUM_CH-1:0] tc_set,
    input  logic [NUM_CH-1:0] err_set,
    output logic [NUM_CH-1:0] chan_enable,
    output logic              irq,
    output logic              dec_err
);
    import dma_rf_pkg::*;

    localparam int         PAD   = DATA_W - NUM_CH;
    localparam logic [3:0] NCH_W = 4'(NUM_CH);
    localparam logic       FULL  = (NUM_CH == 8);

    logic [2:0]        bank_idx, bank_reg;
    logic [3:0]        gsel;
    logic              in_bank, in_id, in_glob, bank_ok, rd_ok, wr_ok;
    logic [DATA_W-1:0] ch_rd  [NUM_CH];
    logic [DATA_W-1:0] ch_cfg [NUM_CH];
    logic [DATA_W-1:0] bank_val, rd_val, gcfg, sync_w;
    logic [NUM_CH-1:0] tc_mask, err_mask, raw_tc, raw_err, tc_stat, err_stat;

    // Address fields.
    assign in_bank  = (addr[11:8] == 4'h1);
    assign bank_idx = addr[7:5];
    assign bank_reg = addr[4:2];
    assign in_id    = (addr[11:5] == 7'h7F);
    assign in_glob  = (addr[11:6] == 6'd0);
    assign gsel     = addr[5:2];
    assign bank_ok  = in_bank && ({1'b0, bank_idx} < NCH_W) && (bank_reg < 3'd5);

    // Legal read and write offsets.
    always_comb begin
        rd_ok = bank_ok || in_id;
        wr_ok = bank_ok;
        if (in_glob) begin
            case (gsel)
                G_CLR_TC, G_CLR_ERR: begin rd_ok = 1'b0; wr_ok = 1'b1; end
                4'd14, 4'd15:        begin rd_ok = 1'b0; wr_ok = 1'b0; end
                4'd8, 4'd9, 4'd10, 4'd11, G_GCFG, G_SYNC:
                                     begin rd_ok = 1'b1; wr_ok = 1'b1; end
                default:             begin rd_ok = 1'b1; wr_ok = 1'b0; end
            endcase
        end
    end

    // Per-channel banks and the bits taken from each configuration word.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dma_rf_chbank #(.DATA_W(DATA_W)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_en && bank_ok && (bank_idx == 3'(c))),
            .wsel  (bank_reg),
            .wdata (wdata),
            .rsel  (bank_reg),
            .rdata (ch_rd[c]),
            .cfg   (ch_cfg[c])
        );
        assign tc_mask[c]     = ch_cfg[c][TCMASK_BIT];
        assign err_mask[c]    = ch_cfg[c][ERMASK_BIT];
        assign chan_enable[c] = ch_cfg[c][RUN_BIT];
    end

    dma_rf_irq #(.NUM_CH(NUM_CH)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tc_set     (tc_set),
        .err_set    (err_set),
        .tc_clr_we  (wr_en && in_glob && (gsel == G_CLR_TC)),
        .err_clr_we (wr_en && in_glob && (gsel == G_CLR_ERR)),
        .clr_val    (wdata[NUM_CH-1:0]),
        .tc_mask    (tc_mask),
        .err_mask   (err_mask),
        .raw_tc     (raw_tc),
        .raw_err    (raw_err),
        .tc_stat    (tc_stat),
        .err_stat   (err_stat),
        .irq        (irq)
    );

    // Global configuration and sync words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gcfg   <= '0;
            sync_w <= '0;
        end else if (wr_en && in_glob) begin
            if (gsel == G_GCFG) gcfg   <= wdata;
            if (gsel == G_SYNC) sync_w <= wdata;
        end
    end

    // Pick the addressed channel's word.
    always_comb begin
        bank_val = '0;
        for (int c = 0; c < NUM_CH; c++)
            if (bank_idx == 3'(c)) bank_val = ch_rd[c];
    end

    // Read value for the current address; invalid offsets give zero.
    always_comb begin
        rd_val = '0;
        if (bank_ok) begin
            rd_val = bank_val;
        end else if (in_id) begin
            rd_val = {{(DATA_W-8){1'b0}}, id_byte(addr[4:2], FULL)};
        end else if (in_glob) begin
            case (gsel)
                G_STAT_ALL: rd_val = {{PAD{1'b0}}, tc_stat | err_stat};
                G_STAT_TC:  rd_val = {{PAD{1'b0}}, tc_stat};
                G_STAT_ERR: rd_val = {{PAD{1'b0}}, err_stat};
                G_RAW_TC:   rd_val = {{PAD{1'b0}}, raw_tc};
                G_RAW_ERR:  rd_val = {{PAD{1'b0}}, raw_err};
                G_ENABLES:  rd_val = {{PAD{1'b0}}, chan_enable};
                G_GCFG:     rd_val = gcfg;
                G_SYNC:     rd_val = sync_w;
                default:    rd_val = '0;
            endcase
        end
    end

    // Register read data and the sticky decode-error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata   <= '0;
            dec_err <= 1'b0;
        end else begin
            if (rd_en) rdata <= rd_val;
            if ((rd_en && !rd_ok) || (wr_en && !wr_ok)) dec_err <= 1'b1;
        end
    end
endmodule

// File: rtl/dma_regfront_chk.sv
// Checker for dma_regfront, bound to every instance. Assumes rd_en and
// wr_en are exclusive and no set pulse coincides with a checked clear.
module dma_regfront_chk #(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic              wr_en,
    input logic [11:0]       addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic [NUM_CH-1:0] tc_set,
    input logic [NUM_CH-1:0] err_set,
    input logic [NUM_CH-1:0] raw_tc,
    input logic [NUM_CH-1:0] raw_err,
    input logic              irq,
    input logic              dec_err
);
    assert_tc_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_set != '0) |=> ((raw_tc & $past(tc_set)) == $past(tc_set)));

    assert_err_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (err_set != '0) |=> ((raw_err & $past(err_set)) == $past(err_set)));

    assert_tc_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr[11:2] == 10'd2 && tc_set == '0)
        |=> ((raw_tc & $past(wdata[NUM_CH-1:0])) == '0));

    assert_err_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr[11:2] == 10'd4 && err_set == '0)
        |=> ((raw_err & $past(wdata[NUM_CH-1:0])) == '0));

    assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_tc == '0 && raw_err == '0) |-> !irq);

    assert_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        dec_err |=> dec_err);

    assert_rdata_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
endmodule

bind dma_regfront dma_regfront_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .tc_set  (tc_set),
    .err_set (err_set),
    .raw_tc  (raw_tc),
    .raw_err (raw_err),
    .irq     (irq),
    .dec_err (dec_err)
);

// File: tb/sim_dma_regfront.sv
`timescale 1ns/1ps
// Bench for dma_regfront with four channels: sweeps banks, ID bytes,
// mask patterns, clears and invalid offsets with computed expectations.
module sim_dma_regfront;
    localparam int NCH = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            rd_en = 1'b0, wr_en = 1'b0;
    logic [11:0]     addr = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic [NCH-1:0]  tc_set = '0, err_set = '0, chan_enable;
    logic            irq, dec_err;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    dma_regfront #(.NUM_CH(NCH), .DATA_W(32)) u0 (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tc_set(tc_set), .err_set(err_set),
        .chan_enable(chan_enable), .irq(irq), .dec_err(dec_err)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; d = rdata;
    endtask

    function automatic logic [31:0] pat(input int c, input int r);
        return 32'h5A00_0000 ^ (c << 12) ^ (r << 4) ^ (c * 7 + r);
    endfunction

    function automatic logic [31:0] cfg_addr(input int c);
        return 32'h110 + 32 * c;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [NCH-1:0] rtc, rerr, e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rdata", rdata, 0);
        chk("R1 irq", {31'd0, irq}, 0);
        chk("R1 dec_err", {31'd0, dec_err}, 0);
        chk("R1 chan_enable", {28'd0, chan_enable}, 0);
        rd(12'h014, v); chk("R1 raw tc", v, 0);
        rd(12'h018, v); chk("R1 raw err", v, 0);
        rd(12'h130, v); chk("R1 bank word", v, 0);

        // R2 bank sweep (configuration word avoids enable and mask bits)
        for (int c = 0; c < NCH; c++)
            for (int r = 0; r < 5; r++)
                wr(12'(32'h100 + 32 * c + 4 * r), (r == 4) ? (pat(c, r) & 32'hFFFF_3FFE) : pat(c, r));
        for (int c = 0; c < NCH; c++)
            for (int r = 0; r < 5; r++) begin
                rd(12'(32'h100 + 32 * c + 4 * r), v);
                chk("R2 bank readback", v, (r == 4) ? (pat(c, r) & 32'hFFFF_3FFE) : pat(c, r));
            end
        for (int c = 0; c < NCH; c++) wr(12'(cfg_addr(c)), 0);

        // R3 global configuration and sync
        wr(12'h030, 32'hDEAD_0001); wr(12'h034, 32'h0000_BEEF);
        rd(12'h030, v); chk("R3 gcfg", v, 32'hDEAD_0001);
        rd(12'h034, v); chk("R3 sync", v, 32'h0000_BEEF);

        // R10 identification bytes (four channels: first byte 0x81)
        for (int i = 0; i < 8; i++) begin
            logic [7:0] idb [8];
            idb = '{8'h81, 8'h10, 8'h04, 8'h0A, 8'h0D, 8'hF0, 8'h05, 8'hB1};
            rd(12'(32'hFE0 + 4 * i), v); chk("R10 id byte", v, {24'd0, idb[i]});
        end

        // R11 soft-request offsets
        for (int i = 0; i < 4; i++) begin
            wr(12'(32'h020 + 4 * i), 32'hFFFF_FFFF);
            rd(12'(32'h020 + 4 * i), v); chk("R11 soft reads zero", v, 0);
        end
        chk("R11 no dec_err", {31'd0, dec_err}, 0);

        // R9 enabled readback
        wr(12'(cfg_addr(0)), 1); wr(12'(cfg_addr(2)), 1);
        rd(12'h01C, v); chk("R9 enables word", v, 32'h5);
        chk("R9 chan_enable", {28'd0, chan_enable}, 32'h5);
        wr(12'(cfg_addr(0)), 0); wr(12'(cfg_addr(2)), 0);
        chk("R9 chan_enable cleared", {28'd0, chan_enable}, 0);

        // R4 raw set, R8 irq stays low with masks off
        rtc = 4'b1011; rerr = 4'b0110;
        @(negedge clk); tc_set = rtc; err_set = rerr;
        @(negedge clk); tc_set = '0; err_set = '0;
        chk("R8 irq masked off", {31'd0, irq}, 0);
        rd(12'h014, v); chk("R4 raw tc", v, {28'd0, rtc});
        rd(12'h018, v); chk("R4 raw err", v, {28'd0, rerr});

        // R13 read data held without rd_en
        repeat (3) @(negedge clk);
        chk("R13 rdata held", rdata, {28'd0, rerr});

        // R7/R8 mask sweep
        for (int m = 0; m < 16; m++) begin
            e = 4'(m) ^ 4'b0101;
            for (int c = 0; c < NCH; c++)
                wr(12'(cfg_addr(c)), (32'(m >> c & 1) << 15) | (32'(e[c]) << 14));
            rd(12'h004, v); chk("R7 masked tc", v, {28'd0, rtc & 4'(m)});
            rd(12'h00C, v); chk("R7 masked err", v, {28'd0, rerr & e});
            rd(12'h000, v); chk("R7 combined", v, {28'd0, (rtc & 4'(m)) | (rerr & e)});
            chk("R8 irq", {31'd0, irq}, {31'd0, |((rtc & 4'(m)) | (rerr & e))});
        end

        // R5 clears
        wr(12'h008, 32'h1);
        rd(12'h014, v); chk("R5 tc clear", v, 32'hA);
        wr(12'h010, 32'h4);
        rd(12'h018, v); chk("R5 err clear", v, 32'h2);

        // R6 set beats clear in the same cycle
        @(negedge clk); wr_en = 1'b1; addr = 12'h008; wdata = 32'hF; tc_set = 4'b0100;
        @(negedge clk); wr_en = 1'b0; tc_set = '0;
        rd(12'h014, v); chk("R6 set wins", v, 32'h4);

        // R12 invalid accesses
        chk("R12 no error yet", {31'd0, dec_err}, 0);
        rd(12'h1A0, v); chk("R12 bank out of range reads zero", v, 0);
        chk("R12 dec_err set", {31'd0, dec_err}, 1);
        rd(12'h030, v); chk("R12 sticky", {31'd0, dec_err}, 1);
        rd(12'h114, v); chk("R12 bank word 5 reads zero", v, 0);
        rd(12'h008, v); chk("R12 clear reg reads zero", v, 0);
        wr(12'h014, 32'hF);
        rd(12'h014, v); chk("R12 raw write ignored", v, 32'h4);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule